// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Space Identifiers

This block holds a small set of recently used page translations and searches all of them in parallel in one cycle. A request carries a 32-bit virtual address and an 8-bit address space identifier. Pages are 4 KB, so the upper 20 address bits form the virtual page number and the lower 12 bits are the byte offset. An entry matches when it is valid and both its page number and its space identifier equal the request. A single match returns a 24-bit physical address, which is the stored 12-bit physical page number followed by the unchanged offset, together with the entry's dirty and reference bits.

Each entry also records whether it has been accessed. A successful translation sets the entry's reference bit, and a bulk clear input zeroes every reference bit, so that software can sample page use over a period. Entries are loaded through a write port. The target is either the entry named by an index register or the entry named by a random register. The random register counts down on every clock and wraps so that it never reaches the lowest, pinned entries. A store to a page whose dirty bit is clear raises a modification exception instead of translating. Two or more matching entries raise an error flag. Page table walking and fault handling belong to the surrounding logic.

Top module: `xlat_cam`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss, and `rand_idx` reads ENTRIES-1 (31 by default).
- R2: A lookup that matches exactly one entry raises `hit` in the same cycle. `paddr` is the entry's physical page number in bits 23:12 and `lk_vaddr[11:0]` in bits 11:0, and `rsp_dirty` gives the entry's dirty bit.
- R3: The space identifier takes part in the match. The same page number with a different identifier misses.
- R4: A lookup with no match raises `miss`, drives `paddr` to zero and changes no entry. In particular, no reference bit changes.
- R5: `rsp_ref` reports the stored reference bit as it was before the access. A hit sets that bit at the next clock edge, and a newly written entry starts with its reference bit clear.
- R6: A pulse on `ref_clr` clears the reference bits of all entries.
- R7: When `wr_en` is high and `wr_rand`=0, the write goes to the entry held in the index register. `idx_we` loads `idx_din` into that register at the clock edge.
- R8: The random register decrements once per clock. When it is at WIRED (4 by default) it reloads ENTRIES-1, so it stays within [WIRED, ENTRIES-1]. When `wr_en` is high and `wr_rand`=1, the write goes to the entry that `rand_idx` shows in that cycle.
- R9: A store lookup (`lk_store`=1) that matches an entry whose dirty bit is clear raises `mod_exc`. In that case `hit` stays low, `paddr` is zero and the reference bit is not set.
- R10: When more than one entry matches, `multi_hit` is raised and `hit` and `miss` stay low.
- R11: `inv_all` clears every valid bit. A write with `wr_valid`=0 invalidates the single target entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_en | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_asid | input | 8 | Address space identifier of the request |
| lk_store | input | 1 | Request is a store |
| hit | output | 1 | Single match, translation valid |
| miss | output | 1 | No entry matched |
| multi_hit | output | 1 | More than one entry matched |
| mod_exc | output | 1 | Store to a clean page |
| paddr | output | 24 | Translated physical address |
| rsp_dirty | output | 1 | Dirty bit of the hit entry |
| rsp_ref | output | 1 | Reference bit of the hit entry before this access |
| idx_we | input | 1 | Load the index register |
| idx_din | input | 5 | New index register value |
| wr_en | input | 1 | Write an entry |
| wr_rand | input | 1 | 1: random target, 0: indexed target |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_asid | input | 8 | Space identifier to store |
| wr_ppn | input | 12 | Physical page number to store |
| wr_dirty | input | 1 | Dirty bit to store |
| wr_valid | input | 1 | Valid bit to store |
| ref_clr | input | 1 | Clear all reference bits |
| inv_all | input | 1 | Invalidate all entries |
| rand_idx | output | 5 | Current random register value |

## Verification
On every cycle the assertions check that hit, miss, multi-hit and modification exception are mutually exclusive, that the random register stays in range and steps correctly, that a miss leaves the reference bits alone, that a hit sets its reference bit, and that the bulk clear and bulk invalidate take effect at the next edge. Only the bench scenarios can show the translated address values, the effect of the space identifier on matching, and where an indexed or random write actually lands. They also show that the pinned entries survive a long run of random writes.

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int ENTRIES = 32,
  parameter int WIRED   = 4,
  parameter int VA_W    = 32,
  parameter int PA_W    = 24,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lk_en,
  input  logic [VA_W-1:0]            lk_vaddr,
  input  logic [ASID_W-1:0]          lk_asid,
  input  logic                       lk_store,
  output logic                       hit,
  output logic                       miss,
  output logic                       multi_hit,
  output logic                       mod_exc,
  output logic [PA_W-1:0]            paddr,
  output logic                       rsp_dirty,
  output logic                       rsp_ref,
  input  logic                       idx_we,
  input  logic [$clog2(ENTRIES)-1:0] idx_din,
  input  logic                       wr_en,
  input  logic                       wr_rand,
  input  logic [VA_W-OFF_W-1:0]      wr_vpn,
  input  logic [ASID_W-1:0]          wr_asid,
  input  logic [PA_W-OFF_W-1:0]      wr_ppn,
  input  logic                       wr_dirty,
  input  logic                       wr_valid,
  input  logic                       ref_clr,
  input  logic                       inv_all,
  output logic [$clog2(ENTRIES)-1:0] rand_idx
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] LOW = IDX_W'(WIRED);

  logic [VPN_W-1:0]  vpn_q  [ENTRIES];
  logic [ASID_W-1:0] asid_q [ENTRIES];
  logic [PPN_W-1:0]  ppn_q  [ENTRIES];
  logic [ENTRIES-1:0] valid_q, dirty_q, ref_q, match;
  logic [IDX_W-1:0] idx_q, rnd_q, sel, wr_tgt;
  logic any, multi, single, clean_store;

  wire [VPN_W-1:0] req_vpn = lk_vaddr[VA_W-1:OFF_W];

  // random victim pointer, never below the pinned entries
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              rnd_q <= TOP;
    else if (rnd_q == LOW)   rnd_q <= TOP;
    else                     rnd_q <= rnd_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      idx_q <= '0;
    else if (idx_we) idx_q <= idx_din;

  assign rand_idx = rnd_q;
  assign wr_tgt   = wr_rand ? rnd_q : idx_q;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = lk_en && valid_q[g] && (vpn_q[g] == req_vpn) && (asid_q[g] == lk_asid);
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (match[e]) sel = IDX_W'(e);
  end

  assign any         = |match;
  assign multi       = (match & (match - 1'b1)) != '0;
  assign single      = any && !multi;
  assign clean_store = single && lk_store && !dirty_q[sel];
  assign hit         = single && !clean_store;
  assign mod_exc     = clean_store;
  assign miss        = lk_en && !any;
  assign multi_hit   = multi;
  assign paddr       = hit ? {ppn_q[sel], lk_vaddr[OFF_W-1:0]} : '0;
  assign rsp_dirty   = hit && dirty_q[sel];
  assign rsp_ref     = hit && ref_q[sel];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      ref_q   <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        vpn_q[e]  <= '0;
        asid_q[e] <= '0;
        ppn_q[e]  <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (wr_en && wr_tgt == IDX_W'(e)) begin
          vpn_q[e]   <= wr_vpn;
          asid_q[e]  <= wr_asid;
          ppn_q[e]   <= wr_ppn;
          dirty_q[e] <= wr_dirty;
          valid_q[e] <= wr_valid && !inv_all;
          ref_q[e]   <= 1'b0;
        end else begin
          if (inv_all) valid_q[e] <= 1'b0;
          if (ref_clr) ref_q[e] <= 1'b0;
          else if (hit && sel == IDX_W'(e)) ref_q[e] <= 1'b1;
        end
      end
    end

  assert_outcome_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, miss, multi_hit, mod_exc}));

  assert_rand_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rand_idx >= LOW && rand_idx <= TOP);

  assert_rand_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rand_idx == (($past(rand_idx) == LOW) ? TOP : $past(rand_idx) - 1'b1));

  assert_miss_keeps_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !wr_en && !ref_clr) |=> $stable(ref_q));

  assert_hit_sets_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !wr_en && !ref_clr) |=> ref_q[$past(sel)]);

  assert_ref_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_clr |=> ref_q == '0);

  assert_inval_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> valid_q == '0);

  assert_clean_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mod_exc |-> (paddr == '0 && !hit));
endmodule

// File: tb/test_xlat_cam.sv
module test_xlat_cam;
  logic clk = 0, rst_n = 0;
  logic lk_en = 0, lk_store = 0, idx_we = 0, wr_en = 0, wr_rand = 0;
  logic wr_dirty = 0, wr_valid = 0, ref_clr = 0, inv_all = 0;
  logic [31:0] lk_vaddr = 0;
  logic [7:0] lk_asid = 0, wr_asid = 0;
  logic [4:0] idx_din = 0;
  logic [19:0] wr_vpn = 0;
  logic [11:0] wr_ppn = 0;
  logic hit, miss, multi_hit, mod_exc, rsp_dirty, rsp_ref;
  logic [23:0] paddr;
  logic [4:0] rand_idx;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  xlat_cam i_xlat_cam (.clk, .rst_n, .lk_en, .lk_vaddr, .lk_asid, .lk_store,
    .hit, .miss, .multi_hit, .mod_exc, .paddr, .rsp_dirty, .rsp_ref,
    .idx_we, .idx_din, .wr_en, .wr_rand, .wr_vpn, .wr_asid, .wr_ppn,
    .wr_dirty, .wr_valid, .ref_clr, .inv_all, .rand_idx);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_idx(input logic [4:0] i);
    @(negedge clk); idx_we = 1; idx_din = i;
    @(negedge clk); idx_we = 0;
  endtask

  task automatic wr(input bit rnd, input logic [19:0] vpn, input logic [7:0] asid,
                    input logic [11:0] ppn, input bit d, input bit v, output logic [4:0] slot);
    @(negedge clk);
    wr_en = 1; wr_rand = rnd; wr_vpn = vpn; wr_asid = asid; wr_ppn = ppn;
    wr_dirty = d; wr_valid = v; slot = rand_idx;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wr_at(input logic [4:0] i, input logic [19:0] vpn, input logic [7:0] asid,
                       input logic [11:0] ppn, input bit d, input bit v);
    logic [4:0] s;
    set_idx(i);
    wr(0, vpn, asid, ppn, d, v, s);
  endtask

  task automatic pulse_inv();
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
  endtask

  // result vector {hit, miss, multi_hit, mod_exc}
  task automatic look(string tag, input logic [31:0] va, input logic [7:0] asid, input bit st,
                      input logic [3:0] exp_res, input logic [23:0] exp_pa, input bit exp_ref);
    @(negedge clk); lk_en = 1; lk_vaddr = va; lk_asid = asid; lk_store = st;
    #1;
    chk({tag, " result"}, {28'd0, hit, miss, multi_hit, mod_exc}, {28'd0, exp_res});
    chk({tag, " paddr"}, {8'd0, paddr}, {8'd0, exp_pa});
    chk({tag, " ref"}, {31'd0, rsp_ref}, {31'd0, exp_ref});
    @(negedge clk); lk_en = 0; lk_store = 0;
  endtask

  task automatic t_reset();
    chk("R1 rand_idx after reset", {27'd0, rand_idx}, 32'd31);
    look("R1 empty lookup", 32'h0000_0123, 8'd0, 0, 4'b0100, 24'h0, 0);
  endtask

  task automatic t_basic();
    pulse_inv();
    wr_at(5'd3, 20'h12345, 8'd7, 12'hABC, 1, 1);
    wr_at(5'd10, 20'hFFFFF, 8'd200, 12'h001, 0, 1);
    @(negedge clk); lk_en = 1; lk_vaddr = 32'h1234_5678; lk_asid = 8'd7; #1;
    chk("R2 dirty reported", {31'd0, rsp_dirty}, 32'd1);
    @(negedge clk); lk_en = 0;
    look("R2 hit entry3", 32'h1234_5678, 8'd7, 0, 4'b1000, 24'hABC678, 1);
    look("R2 hit entry10", 32'hFFFF_F000, 8'd200, 0, 4'b1000, 24'h001000, 0);
    look("R3 other asid", 32'h1234_5678, 8'd8, 0, 4'b0100, 24'h0, 0);
    look("R4 unknown vpn", 32'h1234_6678, 8'd7, 0, 4'b0100, 24'h0, 0);
  endtask

  task automatic t_ref();
    pulse_inv();
    wr_at(5'd9, 20'h00999, 8'd1, 12'h099, 1, 1);
    look("R5 first access ref clear", 32'h0099_9004, 8'd1, 0, 4'b1000, 24'h099004, 0);
    look("R5 second access ref set", 32'h0099_9004, 8'd1, 0, 4'b1000, 24'h099004, 1);
    look("R4 miss lookup", 32'h0088_8000, 8'd1, 0, 4'b0100, 24'h0, 0);
    look("R4 ref kept after miss", 32'h0099_9000, 8'd1, 0, 4'b1000, 24'h099000, 1);
    @(negedge clk); ref_clr = 1;
    @(negedge clk); ref_clr = 0;
    look("R6 ref after clear", 32'h0099_9000, 8'd1, 0, 4'b1000, 24'h099000, 0);
    wr_at(5'd9, 20'h00999, 8'd1, 12'h09A, 1, 1);
    look("R5 rewrite clears ref", 32'h0099_9000, 8'd1, 0, 4'b1000, 24'h09A000, 0);
  endtask

  task automatic t_modexc();
    pulse_inv();
    wr_at(5'd2, 20'h00555, 8'd3, 12'h555, 0, 1);
    wr_at(5'd4, 20'h00444, 8'd3, 12'h444, 1, 1);
    look("R9 store clean page", 32'h0055_5010, 8'd3, 1, 4'b0001, 24'h0, 0);
    look("R9 no ref set by store", 32'h0055_5010, 8'd3, 0, 4'b1000, 24'h555010, 0);
    look("R9 store dirty page", 32'h0044_4020, 8'd3, 1, 4'b1000, 24'h444020, 0);
  endtask

  task automatic t_multi();
    logic [4:0] s;
    pulse_inv();
    wr_at(5'd6, 20'h00777, 8'd2, 12'h006, 1, 1);
    wr_at(5'd7, 20'h00777, 8'd2, 12'h007, 1, 1);
    look("R10 double match", 32'h0077_7000, 8'd2, 0, 4'b0010, 24'h0, 0);
    wr(0, 20'h00777, 8'd2, 12'h007, 1, 0, s);
    look("R11 single invalidate", 32'h0077_7000, 8'd2, 0, 4'b1000, 24'h006000, 0);
    pulse_inv();
    look("R11 invalidate all", 32'h0077_7000, 8'd2, 0, 4'b0100, 24'h0, 0);
  endtask

  task automatic t_index();
    pulse_inv();
    @(negedge clk); idx_we = 1; idx_din = 5'd20;
    @(negedge clk); idx_we = 0; wr_en = 1; wr_rand = 0; wr_vpn = 20'h0ABCD;
    wr_asid = 8'd9; wr_ppn = 12'h020; wr_dirty = 1; wr_valid = 1;
    @(negedge clk); wr_en = 0;
    look("R7 indexed write lands", 32'h0ABC_D111, 8'd9, 0, 4'b1000, 24'h020111, 0);
    wr_at(5'd20, 20'h0BBBB, 8'd9, 12'h021, 1, 1);
    look("R7 same index replaces", 32'h0ABC_D111, 8'd9, 0, 4'b0100, 24'h0, 0);
  endtask

  task automatic t_random();
    logic [4:0] prev, s;
    @(negedge clk); prev = rand_idx;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk("R8 rand step", {27'd0, rand_idx}, {27'd0, (prev == 5'd4) ? 5'd31 : prev - 5'd1});
      prev = rand_idx;
    end
    pulse_inv();
    wr(1, 20'h0CAFE, 8'd5, 12'h0CA, 1, 1, s);
    chk("R8 victim not pinned", {31'd0, s >= 5'd4}, 32'd1);
    look("R8 random write hits", 32'h0CAF_E000, 8'd5, 0, 4'b1000, 24'h0CA000, 0);
    wr_at(s, 20'h0D00D, 8'd5, 12'h0D0, 1, 1);
    look("R8 random slot was rand_idx", 32'h0CAF_E000, 8'd5, 0, 4'b0100, 24'h0, 0);
  endtask

  task automatic t_wired();
    logic [4:0] s;
    pulse_inv();
    for (int i = 0; i < 4; i++) wr_at(5'(i), 20'h00100 + 20'(i), 8'd1, 12'h040 + 12'(i), 1, 1);
    for (int k = 0; k < 40; k++) wr(1, 20'h00200 + 20'(k), 8'd1, 12'h100, 1, 1, s);
    for (int i = 0; i < 4; i++)
      look("R8 pinned entry survives", {20'h00100 + 20'(i), 12'h000}, 8'd1, 0, 4'b1000,
           {12'h040 + 12'(i), 12'h000}, 0);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_basic();
    t_ref();
    t_modexc();
    t_multi();
    t_index();
    t_random();
    t_wired();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule